// File: doc/BRIEF.md
# Vector Row Load/Store Aligner

This unit sits between a vector register file and a byte-addressed memory built from rows that are each exactly one vector wide. The default vector is 128 bytes. The unit takes one request at a time: a byte address, an operation code and, for stores, a full vector of write data. It turns that request into one or two row accesses on a synchronous single-port memory. Each row access carries a row index, a per-byte write-enable mask and byte-rotated write data.

Aligned operations always act on the whole row that holds the address, so the low address bits have no effect. Unaligned operations treat the address as an exact byte position. For a nonzero in-row offset the unit makes two row accesses back to back: row n first, then row n+1. The two halves are joined with a byte-granular barrel rotator whose shift amount is the in-row offset.

Requests use a valid/ready handshake. A request transfers on a rising edge where both `req_valid` and `req_ready` are high, and `req_ready` stays low until the current operation has finished. A load completes with a single-cycle `rsp_valid` pulse that carries the assembled vector. The response path has no back-pressure, so the consumer must take the data in that cycle. The memory side is plain control with no handshake, and read data returns one cycle after the access.

Top module: `vec_mem_access`

## Requirements
- R1: The operation code `req_op` has bit 0 set for unaligned and bit 1 set for store. Code 0 is aligned load, 1 is unaligned load, 2 is aligned store and 3 is unaligned store. `req_ready` is high only while the unit is idle, and it is low in every cycle of an operation that has been accepted.
- R2: An aligned load returns the entire row `addr >> log2(VEC_BYTES)`. Its result is the same for every value of the low address bits.
- R3: An unaligned load at in-row offset k returns the vector of consecutive bytes that begins at byte address `addr`. Result byte j (bits [8j+7:8j]) equals memory byte `addr + j`, taken modulo the memory size. The result is made of bytes k..VEC_BYTES-1 of row n followed by bytes 0..k-1 of row n+1.
- R4: An aligned store writes the whole row that contains the address, with every byte enable set. Vector byte j lands in byte j of that row, whatever the low address bits are.
- R5: An unaligned store with nonzero offset k writes vector byte 0 to memory byte `addr`. It makes exactly two row writes: row n with enables on bytes k..VEC_BYTES-1, then row n+1 with enables on bytes 0..k-1. Every other byte of memory keeps its old value.
- R6: An unaligned access whose offset is 0 uses a single row access and gives the same result and timing as the matching aligned access.
- R7: A load raises `rsp_valid` for exactly one cycle. For a one-row load this happens 2 cycles after acceptance, and for a two-row load 3 cycles after acceptance, in the cycle after the last row read.
- R8: A store returns `req_ready` high 2 cycles after acceptance when it uses one row, and 3 cycles after acceptance when it uses two rows.
- R9: A load never asserts `mem_we` and leaves memory contents unchanged.
- R10: While reset is asserted and right after it, `req_ready` is 1, and `mem_en` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle; request transfers when valid and ready are both high |
| req_op | input | 2 | bit0 = unaligned, bit1 = store |
| req_addr | input | ADDR_W (10) | Byte address |
| req_wdata | input | VEC_BYTES*8 (1024) | Store vector, byte j in bits [8j+7:8j] |
| rsp_valid | output | 1 | One-cycle load result strobe |
| rsp_data | output | VEC_BYTES*8 (1024) | Load result vector |
| mem_en | output | 1 | Row access this cycle |
| mem_we | output | 1 | Row access is a write |
| mem_row | output | ADDR_W-log2(VEC_BYTES) (3) | Row index |
| mem_be | output | VEC_BYTES (128) | Per-byte write enables |
| mem_wdata | output | VEC_BYTES*8 (1024) | Rotated row write data |
| mem_rdata | input | VEC_BYTES*8 (1024) | Row read data, one cycle after the access |

## Verification
The embedded assertions check the access pattern on every cycle:
- the memory is never driven while the unit is idle;
- a second consecutive row access always targets the next row;
- the two enable masks of a split access never overlap and together cover the row;
- every response is a single pulse that follows a read.

Byte placement can only be shown by the bench's scenarios, because it depends on memory contents. These scenarios cover the rotated content of loads and stores at every in-row offset, the preserved bytes around an unaligned store, the insensitivity of aligned accesses to the low bits, and the cycle counts.

// File: rtl/vma_pkg.sv
package vma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW0 = 2'd1,
    ST_ROW1 = 2'd2,
    ST_DONE = 2'd3
  } vma_state_e;
endpackage

// File: rtl/vma_byte_rot.sv
// Byte-granular barrel rotator, log2(NB) stages.
// ROT_UP=1: byte i moves to byte (i+amt) mod NB; ROT_UP=0: the inverse.
module vma_byte_rot #(
  parameter int NB     = 128,
  parameter bit ROT_UP = 1'b1,
  localparam int W     = NB * 8,
  localparam int SW    = $clog2(NB)
) (
  input  logic [W-1:0]  in_vec,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  out_vec
);
  logic [W-1:0] stage [SW+1];

  assign stage[0] = in_vec;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int SH = (1 << k) * 8;
    if (ROT_UP) begin : g_up
      assign stage[k+1] = amt[k] ? {stage[k][W-SH-1:0], stage[k][W-1:W-SH]} : stage[k];
    end else begin : g_dn
      assign stage[k+1] = amt[k] ? {stage[k][SH-1:0], stage[k][W-1:SH]} : stage[k];
    end
  end

  assign out_vec = stage[SW];
endmodule

// File: rtl/vma_edge_mask.sv
// Splits a row at byte offset off: upper covers bytes >= off, lower bytes < off.
module vma_edge_mask #(
  parameter int NB  = 128,
  localparam int OW = $clog2(NB)
) (
  input  logic [OW-1:0] off,
  output logic [NB-1:0] upper,
  output logic [NB-1:0] lower
);
  for (genvar p = 0; p < NB; p++) begin : g_byte
    localparam logic [OW-1:0] PV = OW'(p);
    assign upper[p] = (PV >= off);
    assign lower[p] = (PV <  off);
  end
endmodule

// File: rtl/vec_mem_access.sv
module vec_mem_access
  import vma_pkg::*;
#(
  parameter int VEC_BYTES = 128,
  parameter int ADDR_W    = 10,
  localparam int VW       = VEC_BYTES * 8,
  localparam int OFF_W    = $clog2(VEC_BYTES),
  localparam int ROW_W    = ADDR_W - OFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [VW-1:0]        req_wdata,
  output logic                 rsp_valid,
  output logic [VW-1:0]        rsp_data,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [ROW_W-1:0]     mem_row,
  output logic [VEC_BYTES-1:0] mem_be,
  output logic [VW-1:0]        mem_wdata,
  input  logic [VW-1:0]        mem_rdata
);
  vma_state_e          state_q;
  logic                store_q;
  logic [ROW_W-1:0]    row_q;
  logic [OFF_W-1:0]    off_q;   // forced to 0 for aligned operations
  logic [VW-1:0]       wdata_q;
  logic [VW-1:0]       lo_q;    // first row of a split load
  logic                split;
  logic [VEC_BYTES-1:0] upper_m, lower_m, keep_lo;
  logic [VW-1:0]       keep_bits, merged, wr_rot;

  assign split     = (off_q != '0);
  assign req_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      store_q <= 1'b0;
      row_q   <= '0;
      off_q   <= '0;
      wdata_q <= '0;
      lo_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          store_q <= req_op[1];
          row_q   <= req_addr[ADDR_W-1:OFF_W];
          off_q   <= req_op[0] ? req_addr[OFF_W-1:0] : '0;
          wdata_q <= req_wdata;
          state_q <= ST_ROW0;
        end
        ST_ROW0: state_q <= split ? ST_ROW1 : (store_q ? ST_IDLE : ST_DONE);
        ST_ROW1: begin
          lo_q    <= mem_rdata;
          state_q <= store_q ? ST_IDLE : ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  vma_edge_mask #(.NB(VEC_BYTES)) u_mask (
    .off   (off_q),
    .upper (upper_m),
    .lower (lower_m)
  );

  vma_byte_rot #(.NB(VEC_BYTES), .ROT_UP(1'b1)) u_wr_rot (
    .in_vec  (wdata_q),
    .amt     (off_q),
    .out_vec (wr_rot)
  );

  // Row access side
  assign mem_en    = (state_q == ST_ROW0) || (state_q == ST_ROW1);
  assign mem_we    = mem_en && store_q;
  assign mem_row   = (state_q == ST_ROW1) ? ROW_W'(row_q + 1'b1) : row_q;
  assign mem_be    = !mem_en ? '0 : ((state_q == ST_ROW1) ? lower_m : upper_m);
  assign mem_wdata = wr_rot;

  // Load assembly: bytes >= off from row n, bytes < off from row n+1
  assign keep_lo = upper_m & {VEC_BYTES{split}};
  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_keep
    assign keep_bits[b*8 +: 8] = {8{keep_lo[b]}};
  end
  assign merged = (lo_q & keep_bits) | (mem_rdata & ~keep_bits);

  vma_byte_rot #(.NB(VEC_BYTES), .ROT_UP(1'b0)) u_rd_rot (
    .in_vec  (merged),
    .amt     (off_q),
    .out_vec (rsp_data)
  );

  assign rsp_valid = (state_q == ST_DONE);

  // Checks
  AST_MEM_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !req_ready); // R1
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(mem_en) && !$past(mem_we))); // R9
  AST_SECOND_ROW_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> (mem_row == ROW_W'($past(mem_row) + 1'b1))); // R5
  AST_SPLIT_BE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> ((mem_be & $past(mem_be)) == '0)); // R5
  AST_SPLIT_BE_COVER: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> (&(mem_be | $past(mem_be)))); // R5
endmodule

// File: tb/vec_mem_access_test.sv
module vec_mem_access_test;
  localparam int VB    = 128;
  localparam int AW    = 10;
  localparam int VW    = VB * 8;
  localparam int OW    = $clog2(VB);
  localparam int RW    = AW - OW;
  localparam int ROWS  = 1 << RW;
  localparam int TOT   = ROWS * VB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [VW-1:0] req_wdata = '0;
  logic rsp_valid;
  logic [VW-1:0] rsp_data;
  logic mem_en, mem_we;
  logic [RW-1:0] mem_row;
  logic [VB-1:0] mem_be;
  logic [VW-1:0] mem_wdata;
  logic [VW-1:0] mem_rdata;

  logic [VW-1:0] mem_q  [ROWS];
  logic [VW-1:0] shadow [ROWS];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;   // 250 MHz

  vec_mem_access #(.VEC_BYTES(VB), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_row(mem_row), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(int r, int b);
    return 8'((r * VB + b) * 37 + 11);
  endfunction

  // Synchronous single-port RAM, read-before-write, filled during reset
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int b = 0; b < VB; b++) mem_q[r][b*8 +: 8] <= pat(r, b);
      mem_rdata <= '0;
    end else if (mem_en) begin
      mem_rdata <= mem_q[mem_row];
      if (mem_we)
        for (int b = 0; b < VB; b++)
          if (mem_be[b]) mem_q[mem_row][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act,
                     input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] exp_load(bit unal, int addr);
    logic [VW-1:0] v;
    int base = unal ? addr : (addr / VB) * VB;
    for (int j = 0; j < VB; j++) begin
      int lin = (base + j) % TOT;
      v[j*8 +: 8] = shadow[lin / VB][(lin % VB)*8 +: 8];
    end
    return v;
  endfunction

  task automatic shadow_store(bit unal, int addr, logic [VW-1:0] wd);
    int base = unal ? addr : (addr / VB) * VB;
    for (int j = 0; j < VB; j++) begin
      int lin = (base + j) % TOT;
      shadow[lin / VB][(lin % VB)*8 +: 8] = wd[j*8 +: 8];
    end
  endtask

  task automatic check_mem(input string req);
    bit ok = 1'b1;
    int bad = 0;
    for (int r = 0; r < ROWS; r++)
      if (mem_q[r] !== shadow[r] && ok) begin ok = 1'b0; bad = r; end
    chk(ok, req, mem_q[bad], shadow[bad]);
  endtask

  // Issue one request and wait for completion; lat counts cycles after acceptance.
  task automatic run_op(input logic [1:0] op, input int addr, input logic [VW-1:0] wd,
                        output logic [VW-1:0] rd, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = AW'(addr); req_wdata = wd;
    lat = 0;
    rd = '0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
      if (lat == 1) chk(!req_ready, "R1 busy", {1023'd0, req_ready}, '0);
      if (!op[1] && rsp_valid) begin rd = rsp_data; break; end
      if (op[1] && req_ready) break;
      if (lat > 10) break;
    end
  endtask

  task automatic do_load(bit unal, int addr, string req);
    logic [VW-1:0] rd, ex;
    int lat, exp_lat;
    ex = exp_load(unal, addr);
    exp_lat = (unal && (addr % VB) != 0) ? 3 : 2;
    run_op({1'b0, unal}, addr, '0, rd, lat);
    chk(rd === ex, req, rd, ex);
    chk(lat == exp_lat, "R7 load latency", VW'(lat), VW'(exp_lat));
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R7 single pulse", {1022'd0, rsp_valid, req_ready}, VW'(1));
    check_mem("R9 load leaves memory");
  endtask

  task automatic do_store(bit unal, int addr, int seed, string req);
    logic [VW-1:0] rd, wd;
    int lat, exp_lat;
    for (int j = 0; j < VB; j++) wd[j*8 +: 8] = 8'(j * 5 + seed * 3 + 1);
    exp_lat = (unal && (addr % VB) != 0) ? 3 : 2;
    shadow_store(unal, addr, wd);
    run_op({1'b1, unal}, addr, wd, rd, lat);
    chk(lat == exp_lat, "R8 store latency", VW'(lat), VW'(exp_lat));
    check_mem(req);
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int b = 0; b < VB; b++) shadow[r][b*8 +: 8] = pat(r, b);
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_en && !rsp_valid, "R10 reset state",
        {1021'd0, req_ready, mem_en, rsp_valid}, VW'(4));
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_en && !rsp_valid, "R10 after reset",
        {1021'd0, req_ready, mem_en, rsp_valid}, VW'(4));

    // Aligned loads: low bits ignored
    for (int r = 0; r < ROWS; r++) begin
      do_load(1'b0, r * VB + 0,   "R2 aligned load");
      do_load(1'b0, r * VB + 13,  "R2 aligned load off13");
      do_load(1'b0, r * VB + 127, "R2 aligned load off127");
    end

    // Unaligned loads over every in-row offset
    for (int k = 0; k < VB; k++) begin
      if (k == 0) do_load(1'b1, (k % 6) * VB + k, "R6 unaligned load off0");
      else        do_load(1'b1, (k % 6) * VB + k, "R3 unaligned load");
    end
    do_load(1'b1, (ROWS - 1) * VB + 40, "R3 unaligned load wrap");

    // Aligned stores: whole row, data unrotated
    do_store(1'b0, 2 * VB + 13, 1, "R4 aligned store off13");
    do_load(1'b0, 2 * VB, "R4 aligned readback");
    do_store(1'b0, 5 * VB + 99, 2, "R4 aligned store off99");

    // Unaligned stores over every offset, each read back unaligned
    for (int k = 0; k < VB; k++) begin
      int a = (k % 6) * VB + k;
      if (k == 0) do_store(1'b1, a, k + 7, "R6 unaligned store off0");
      else        do_store(1'b1, a, k + 7, "R5 unaligned store");
      do_load(1'b1, a, "R3 unaligned readback");
    end

    finish_run();
  end
endmodule